// File: doc/BRIEF.md
# Debug Traffic Counters and Idle Monitor

This block watches handshake strobes on a host-link interface and on an AXI interface, for debug. It keeps a pair of saturating counters for each of nine traffic classes: one for read-side events and one for write-side events. It also raises six idle flags. Each flag reports that one traffic class has been quiet for at least a programmable number of clock cycles. The link side and the AXI side each have their own quiet-period limit.

Software sees the block as a small bank of 64-bit registers. Reads go through a registered read port. Writes go through a plain write strobe with an address and data. A write to offset 0x00 zeroes every counter at once. Two limit registers set the quiet periods. The block also passes through the current occupancy of two data buffers so that they can be read in the same bank. The link protocol itself is decoded elsewhere; this block only sees one strobe per event.

Top module: `dbg_traffic_mon`

## Requirements
- R1: Class c (0 link command, 1 link response, 2 link retry, 3 link fail, 4 translate pending, 5 translate done, 6 translate retry, 7 AXI command, 8 AXI response) is read at byte offset 0x08 + 8*c. The read-event count of the class is in bits [63:32] and its write-event count is in bits [31:0], each zero-extended.
- R2: When `ev_rd_i[c]` or `ev_wr_i[c]` is high at a rising edge, the matching count rises by exactly one at that edge.
- R3: A count that has reached all-ones (width CNT_W) stays there on further events instead of wrapping.
- R4: Any write to offset 0x00 zeroes all eighteen counts at that edge, whatever the write data. If an event strobe arrives on the same edge, the clear wins and the count still becomes zero.
- R5: The idle register is at offset 0x58. Bit 5 is link command idle, fed by class 0 events on either side. Bit 4 is link response idle, fed by class 1 events on either side. Bit 3 is AXI read command idle (`ev_rd_i[7]`), bit 2 is AXI read response idle (`ev_rd_i[8]`), bit 1 is AXI write command idle (`ev_wr_i[7]`) and bit 0 is AXI write response idle (`ev_wr_i[8]`). Bits [63:6] read zero.
- R6: Each idle flag has its own quiet-cycle count. An event of its class resets that count to zero, and every quiet edge adds one until the count reaches the limit. The flag reads 1 whenever the count is at or above the limit. Bits 5 and 4 use the link limit; bits 3 to 0 use the AXI limit.
- R7: The link limit is at offset 0x60 and the AXI limit is at offset 0x68. Both are writable and read back zero-extended. A written value that does not fit in LIM_W bits is stored as all-ones.
- R8: Offset 0x50 returns `buf_rd_occ_i` in bits [63:32] and `buf_wr_occ_i` in bits [31:0].
- R9: The following read as zero: offset 0x00, any offset above 0x68, and any address whose bits [2:0] are not zero. Writes to read-only offsets change nothing.
- R10: After reset all counts are zero, both limits hold LIM_RST, all quiet counts are zero, and `rd_data_o` is zero.
- R11: `rd_data_o` shows, one edge after `rd_addr_i` is sampled, the register value as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_rd_i | input | 9 | Read-side event strobes, one per traffic class |
| ev_wr_i | input | 9 | Write-side event strobes, one per traffic class |
| buf_rd_occ_i | input | OCC_W | Current read-buffer occupancy |
| buf_wr_occ_i | input | OCC_W | Current write-buffer occupancy |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write byte address |
| wr_data_i | input | 64 | Register write data |
| rd_addr_i | input | ADDR_W | Register read byte address |
| rd_data_o | output | 64 | Registered read data |

## Verification
Strobes, clears and limit writes all take effect on the edge that samples them. A read address sampled at the next edge then returns the updated value one edge after that, so a read result is due one edge after its address was sampled. The bench drives inputs on the falling edge. At each rising edge its model first forms the expected read from the state before that edge and only then applies that edge's events and writes. The comparison is made at the following falling edge. Idle flags are checked with the same edge count: a flag with limit L reads set once L quiet edges have passed since the last event.

// File: rtl/dbg_mon_pkg.sv
package dbg_mon_pkg;

    // number of traffic classes, each with a read and a write count
    localparam int NUM_CLS = 9;
    localparam int NUM_IDLE = 6;

    // register indices (byte offset / 8)
    localparam int IDX_CLR  = 0;
    localparam int IDX_CNT0 = 1;
    localparam int IDX_OCC  = 10;
    localparam int IDX_IDLE = 11;
    localparam int IDX_LLIM = 12;
    localparam int IDX_ALIM = 13;

    // classes that feed the idle monitor
    localparam int CLS_LINK_CMD = 0;
    localparam int CLS_LINK_RSP = 1;
    localparam int CLS_AXI_CMD  = 7;
    localparam int CLS_AXI_RSP  = 8;

    // idle flags at or above this bit position use the link limit
    localparam int IDLE_LINK_LO = 4;

endpackage

// File: rtl/dbg_sat_cnt.sv
module dbg_sat_cnt #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (inc_i && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    // R3: a full count never wraps
    a_r3_hold_at_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.cnt == CNT_MAX) && !clr_i |=> (st_q.cnt == CNT_MAX));

    // R4: clear wins over a same-edge event
    a_r4_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (st_q.cnt == '0));

    // R2: an event below the ceiling adds exactly one
    a_r2_step_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
        inc_i && !clr_i && (st_q.cnt != CNT_MAX) |=> (st_q.cnt == $past(st_q.cnt) + 1'b1));

endmodule

// File: rtl/dbg_idle_timer.sv
module dbg_idle_timer #(
    parameter int W = 32
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         act_i,
    input  logic [W-1:0] limit_i,
    output logic         idle_o
);
    typedef struct packed {
        logic [W-1:0] quiet;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (act_i) begin
            st_d.quiet = '0;
        end else if (st_q.quiet < limit_i) begin
            st_d.quiet = st_q.quiet + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign idle_o = (st_q.quiet >= limit_i);

    // R6: any event restarts the quiet count
    a_r6_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        act_i |=> (st_q.quiet == '0));

    // R6: the flag drops after an event unless the limit is zero
    a_r6_flag_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        act_i && (limit_i != '0) |=> (!idle_o || (limit_i == '0)));

    // R6: the quiet count stops once the limit is reached
    a_r6_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.quiet >= limit_i) && !act_i |=> (st_q.quiet == $past(st_q.quiet)));

endmodule

// File: rtl/dbg_traffic_mon.sv
module dbg_traffic_mon
    import dbg_mon_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int LIM_W   = 32,
    parameter int OCC_W   = 16,
    parameter int ADDR_W  = 8,
    parameter int LIM_RST = 1024
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_CLS-1:0] ev_rd_i,
    input  logic [NUM_CLS-1:0] ev_wr_i,
    input  logic [OCC_W-1:0]   buf_rd_occ_i,
    input  logic [OCC_W-1:0]   buf_wr_occ_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [63:0]        wr_data_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [63:0]        rd_data_o
);
    localparam int IDX_W = ADDR_W - 3;
    localparam logic [LIM_W-1:0] LIM_INIT = LIM_W'(LIM_RST);

    typedef struct packed {
        logic [LIM_W-1:0] lim_link;
        logic [LIM_W-1:0] lim_axi;
        logic [63:0]      rd_data;
    } regs_t;

    regs_t st_d, st_q;

    logic [CNT_W-1:0]    rd_cnt [NUM_CLS];
    logic [CNT_W-1:0]    wr_cnt [NUM_CLS];
    logic [NUM_IDLE-1:0] act;
    logic [NUM_IDLE-1:0] idle_vec;
    logic                wr_hit;
    logic                clr_all;
    logic [IDX_W-1:0]    wr_idx;
    logic [IDX_W-1:0]    rd_idx;
    int                  wr_i;
    int                  rd_i;
    logic [63:0]         rd_val;

    function automatic logic [LIM_W-1:0] clamp_lim(input logic [63:0] v);
        if ((v >> LIM_W) != 64'd0) return '1;
        return v[LIM_W-1:0];
    endfunction

    // write decode
    always_comb begin
        wr_idx  = wr_addr_i[ADDR_W-1:3];
        wr_i    = int'(wr_idx);
        wr_hit  = wr_en_i && (wr_addr_i[2:0] == 3'b000);
        clr_all = wr_hit && (wr_i == IDX_CLR);
    end

    // counter pairs, one per class
    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        dbg_sat_cnt #(.W(CNT_W)) i_rd_cnt (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .clr_i  (clr_all),
            .inc_i  (ev_rd_i[c]),
            .cnt_o  (rd_cnt[c])
        );
        dbg_sat_cnt #(.W(CNT_W)) i_wr_cnt (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .clr_i  (clr_all),
            .inc_i  (ev_wr_i[c]),
            .cnt_o  (wr_cnt[c])
        );
    end

    // activity sources of the six idle flags
    assign act[5] = ev_rd_i[CLS_LINK_CMD] | ev_wr_i[CLS_LINK_CMD];
    assign act[4] = ev_rd_i[CLS_LINK_RSP] | ev_wr_i[CLS_LINK_RSP];
    assign act[3] = ev_rd_i[CLS_AXI_CMD];
    assign act[2] = ev_rd_i[CLS_AXI_RSP];
    assign act[1] = ev_wr_i[CLS_AXI_CMD];
    assign act[0] = ev_wr_i[CLS_AXI_RSP];

    for (genvar j = 0; j < NUM_IDLE; j++) begin : g_idle
        localparam bit IS_LINK = (j >= IDLE_LINK_LO);
        dbg_idle_timer #(.W(LIM_W)) i_tmr (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .act_i   (act[j]),
            .limit_i (IS_LINK ? st_q.lim_link : st_q.lim_axi),
            .idle_o  (idle_vec[j])
        );
    end

    // read mux
    always_comb begin
        rd_idx = rd_addr_i[ADDR_W-1:3];
        rd_i   = int'(rd_idx);
        rd_val = '0;
        if (rd_addr_i[2:0] == 3'b000) begin
            for (int c = 0; c < NUM_CLS; c++) begin
                if (rd_i == IDX_CNT0 + c) begin
                    rd_val = (64'(rd_cnt[c]) << 32) | 64'(wr_cnt[c]);
                end
            end
            if (rd_i == IDX_OCC)  rd_val = (64'(buf_rd_occ_i) << 32) | 64'(buf_wr_occ_i);
            if (rd_i == IDX_IDLE) rd_val = 64'(idle_vec);
            if (rd_i == IDX_LLIM) rd_val = 64'(st_q.lim_link);
            if (rd_i == IDX_ALIM) rd_val = 64'(st_q.lim_axi);
        end
    end

    // next state of the register bank
    always_comb begin
        st_d = st_q;
        if (wr_hit && (wr_i == IDX_LLIM)) st_d.lim_link = clamp_lim(wr_data_i);
        if (wr_hit && (wr_i == IDX_ALIM)) st_d.lim_axi  = clamp_lim(wr_data_i);
        st_d.rd_data = rd_val;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.lim_link <= LIM_INIT;
            st_q.lim_axi  <= LIM_INIT;
            st_q.rd_data  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.rd_data;

    // R9: misaligned reads return zero
    a_r9_misaligned_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_addr_i[2:0] != 3'b000) |=> (rd_data_o == 64'd0));

    // R7: the link limit only changes on a write to its offset
    a_r7_link_lim_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_hit && (wr_i == IDX_LLIM)) |=> $stable(st_q.lim_link));

    // R7: the AXI limit only changes on a write to its offset
    a_r7_axi_lim_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_hit && (wr_i == IDX_ALIM)) |=> $stable(st_q.lim_axi));

    // R4: a clear empties the first and last class in the same edge
    a_r4_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_all |=> (rd_cnt[0] == '0) && (wr_cnt[NUM_CLS-1] == '0));

endmodule

// File: tb/test_dbg_traffic_mon.sv
module test_dbg_traffic_mon;
    localparam int CW = 6;
    localparam int LW = 8;
    localparam int OW = 16;
    localparam int AW = 8;
    localparam int LR = 10;
    localparam int NC = 9;
    localparam int CMAX = (1 << CW) - 1;
    localparam int LMAX = (1 << LW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] ev_rd = '0;
    logic [NC-1:0] ev_wr = '0;
    logic [OW-1:0] occ_rd = '0;
    logic [OW-1:0] occ_wr = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [63:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [63:0]   rd_data;

    always #4 clk = ~clk;

    dbg_traffic_mon #(.CNT_W(CW), .LIM_W(LW), .OCC_W(OW), .ADDR_W(AW), .LIM_RST(LR)) i_dbg_traffic_mon (
        .clk_i(clk), .rst_ni(rst_n), .ev_rd_i(ev_rd), .ev_wr_i(ev_wr),
        .buf_rd_occ_i(occ_rd), .buf_wr_occ_i(occ_wr), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    int m_rd[NC];
    int m_wr[NC];
    int m_q[6];
    int m_ll = LR;
    int m_la = LR;
    logic [63:0] exp_rd = '0;
    logic [AW-1:0] seen_addr = '0;

    function automatic bit act_of(int j);
        case (j)
            5: return ev_rd[0] | ev_wr[0];
            4: return ev_rd[1] | ev_wr[1];
            3: return ev_rd[7];
            2: return ev_rd[8];
            1: return ev_wr[7];
            default: return ev_wr[8];
        endcase
    endfunction

    function automatic int lim_of(int j);
        return (j >= 4) ? m_ll : m_la;
    endfunction

    function automatic logic [63:0] model_read(logic [AW-1:0] a);
        int idx;
        logic [63:0] v;
        idx = int'(a) / 8;
        v = '0;
        if (a[2:0] != 3'b000) return '0;
        if (idx >= 1 && idx <= 9) v = {32'(m_rd[idx-1]), 32'(m_wr[idx-1])};
        else if (idx == 10) v = {32'(occ_rd), 32'(occ_wr)};
        else if (idx == 11) begin
            for (int j = 0; j < 6; j++) v[j] = (m_q[j] >= lim_of(j));
        end
        else if (idx == 12) v = 64'(m_ll);
        else if (idx == 13) v = 64'(m_la);
        return v;
    endfunction

    function automatic string tag_of(logic [AW-1:0] a);
        int idx;
        idx = int'(a) / 8;
        if (a[2:0] != 3'b000) return "R9";
        if (idx >= 1 && idx <= 9) return "R2";
        if (idx == 10) return "R8";
        if (idx == 11) return "R6";
        if (idx == 12 || idx == 13) return "R7";
        return "R9";
    endfunction

    task automatic model_reset();
        for (int c = 0; c < NC; c++) begin m_rd[c] = 0; m_wr[c] = 0; end
        for (int j = 0; j < 6; j++) m_q[j] = 0;
        m_ll = LR;
        m_la = LR;
    endtask

    // one rising edge of the reference: read first, then update
    task automatic model_edge();
        int idx;
        bit hit;
        int nq[6];
        exp_rd = model_read(rd_addr);
        for (int j = 0; j < 6; j++) begin
            if (act_of(j)) nq[j] = 0;
            else if (m_q[j] < lim_of(j)) nq[j] = m_q[j] + 1;
            else nq[j] = m_q[j];
        end
        for (int j = 0; j < 6; j++) m_q[j] = nq[j];
        hit = wr_en && (wr_addr[2:0] == 3'b000);
        idx = int'(wr_addr) / 8;
        if (hit && idx == 0) begin
            for (int c = 0; c < NC; c++) begin m_rd[c] = 0; m_wr[c] = 0; end
        end else begin
            for (int c = 0; c < NC; c++) begin
                if (ev_rd[c] && m_rd[c] < CMAX) m_rd[c]++;
                if (ev_wr[c] && m_wr[c] < CMAX) m_wr[c]++;
            end
        end
        if (hit && idx == 12) m_ll = (wr_data > 64'(LMAX)) ? LMAX : int'(wr_data[LW-1:0]);
        if (hit && idx == 13) m_la = (wr_data > 64'(LMAX)) ? LMAX : int'(wr_data[LW-1:0]);
    endtask

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        seen_addr = rd_addr;
        if (rst_n) model_edge();
        else begin model_reset(); exp_rd = '0; end
        @(negedge clk);
        // R11: registered read, compared every cycle against the model
        check(tag_of(seen_addr), rd_data, exp_rd);
    endtask

    task automatic read_reg(logic [AW-1:0] a, logic [63:0] exp, string tag);
        rd_addr = a;
        tick();
        check(tag, rd_data, exp);
    endtask

    task automatic write_reg(logic [AW-1:0] a, logic [63:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic idle_ticks(int n);
        ev_rd = '0; ev_wr = '0;
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        report();
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) tick();
        check("R10", rd_data, 64'd0);                  // R10 output zero in reset
        rst_n = 1'b1;
        read_reg(8'h58, 64'd0, "R10");                 // R10 quiet counts start at zero
        read_reg(8'h68, 64'(LR), "R10");               // R10 limit reset value
        read_reg(8'h08, 64'd0, "R10");

        // random traffic with reads and occasional writes
        for (int k = 0; k < 400; k++) begin
            ev_rd   = NC'($urandom);
            ev_wr   = NC'($urandom) & NC'($urandom);
            occ_rd  = OW'($urandom);
            occ_wr  = OW'($urandom);
            rd_addr = AW'($urandom_range(0, 15) * 8 + (($urandom_range(0, 7) == 0) ? 3 : 0));
            wr_en   = ($urandom_range(0, 9) == 0);
            wr_addr = AW'(8 * (($urandom_range(0, 2) == 0) ? 0 : $urandom_range(12, 13)));
            wr_data = 64'($urandom_range(0, 12));
            tick();
        end
        wr_en = 1'b0;
        idle_ticks(2);

        // R1: field layout of class 2
        write_reg(8'h00, 64'd0);
        ev_rd[2] = 1'b1;
        repeat (3) tick();
        ev_rd = '0; ev_wr[2] = 1'b1;
        repeat (5) tick();
        ev_wr = '0;
        read_reg(8'h18, {32'd3, 32'd5}, "R1");
        read_reg(8'h10, 64'd0, "R1");

        // R9: write to a read-only offset leaves it unchanged
        write_reg(8'h18, '1);
        read_reg(8'h18, {32'd3, 32'd5}, "R9");
        read_reg(8'h70, 64'd0, "R9");
        read_reg(8'h1C, 64'd0, "R9");
        read_reg(8'h00, 64'd0, "R9");

        // R3: saturation at the count ceiling
        ev_rd[7] = 1'b1;
        repeat (CMAX + 7) tick();
        ev_rd = '0;
        read_reg(8'h40, {32'(CMAX), 32'd0}, "R3");

        // R4: clear beats simultaneous events
        ev_rd = '1; ev_wr = '1;
        write_reg(8'h00, 64'h5A5A);
        ev_rd = '0; ev_wr = '0;
        read_reg(8'h40, 64'd0, "R4");
        read_reg(8'h48, 64'd0, "R4");

        // R8: occupancy pass-through
        occ_rd = 16'h1234; occ_wr = 16'hBEEF;
        read_reg(8'h50, 64'h0000_1234_0000_BEEF, "R8");

        // R7: limits and clamping
        write_reg(8'h60, 64'h100);
        read_reg(8'h60, 64'(LMAX), "R7");
        write_reg(8'h60, 64'd5);
        write_reg(8'h68, 64'd3);
        read_reg(8'h60, 64'd5, "R7");
        read_reg(8'h68, 64'd3, "R7");

        // R5/R6: flag mapping and quiet period
        idle_ticks(20);
        ev_rd[0] = 1'b1; ev_wr[7] = 1'b1;
        tick();
        idle_ticks(2);
        read_reg(8'h58, 64'h1D, "R5");
        idle_ticks(2);
        read_reg(8'h58, 64'h3F, "R6");
        ev_wr[8] = 1'b1;
        tick();
        ev_wr = '0;
        read_reg(8'h58, 64'h3E, "R5");

        idle_ticks(4);
        report();
        $finish;
    end
endmodule